// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Memory Front End

This block connects a byte-wide memory array to an 8051-style microcontroller bus on which the low address byte and the data share the same eight bidirectional lines. The upper five address bits arrive on dedicated inputs. While the address-latch strobe is high, the address flows into an internal holding register. When that strobe goes low, the register keeps the full 13-bit address for the rest of the access.

Reads can be started by either the program-fetch strobe or the data-read strobe. This places the array in both the program space and the data space of the processor. The block issues one read request to a synchronous array. It then drives the returned byte onto the shared lines after a fixed number of clocks, and releases them when the strobe ends.

A low pulse on the write strobe becomes a single-cycle write request. That request carries the held address and the byte present on the shared lines when the strobe rises. Chip enable must be low for any of this to happen. All bus inputs are brought into the system clock through two-flop synchronizers, and edges are found on the synchronized copies.

Top module: `mux_bus_mem_if`

## Requirements
- R1: While reset is high and after it is released with all strobes idle, the shared lines are not driven and no read or write request is made.
- R2: The address used by an access is the value of {addr_hi_i, ad_io} present just before the latch strobe fell. Changes on ad_io or addr_hi_i after that fall do not alter it.
- R3: With chip enable low and the latch strobe low, lowering the program-fetch strobe returns the byte stored at the held address on ad_io. The byte appears at the fifth rising clock edge after the strobe goes low, and the lines stay released through the fourth edge.
- R4: The data-read strobe gives the same result and timing as the program-fetch strobe.
- R5: The shared lines are released by the second rising edge after the read strobe returns high.
- R6: While the latch strobe is high, the lines are not driven and no read request is made, even with a read strobe low.
- R7: While chip enable is high, no read strobe or write strobe has any effect: the lines stay released and no request of either kind is made.
- R8: A write strobe that goes low and then high with chip enable low produces exactly one write request, one cycle long, at the third rising edge after the strobe rises. The request carries the held address and the byte on ad_io at the rise. The stored byte can then be read back.
- R9: Each fall of a read strobe produces exactly one single-cycle read request.
- R10: Read accesses with the write strobe held high never produce a write request, so the block is read-only in program-memory use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ale_i | input | 1 | Address latch strobe; high passes the address, low holds it |
| ce_n_i | input | 1 | Chip enable, active low |
| psen_n_i | input | 1 | Program-fetch read strobe, active low |
| rd_n_i | input | 1 | Data read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| addr_hi_i | input | 5 | Upper address bits 12..8 |
| ad_io | inout | 8 | Shared low address / data lines |
| mem_rd_en_o | output | 1 | Single-cycle read request to the array |
| mem_rd_addr_o | output | 13 | Read address |
| mem_rd_data_i | input | 8 | Array read data, valid the cycle after the request |
| mem_wr_en_o | output | 1 | Single-cycle write request |
| mem_wr_addr_o | output | 13 | Write address |
| mem_wr_data_o | output | 8 | Write data |

## Verification
If the address holding register kept updating after the latch strobe fell, the read-back byte would belong to the garbage address the bench places on the lines afterwards. That wrong byte would show on ad_io at the fifth edge of the same read. A stuck read pending or data-valid flag would drive the lines too early or too late, and this is caught at the fourth or fifth edge after the strobe falls. A write-arming state that was wrong would produce a missing, duplicated or misplaced write request. That is seen within three edges of the strobe rise, and again when the byte is read back.

// File: rtl/bus_if_pkg.sv
package bus_if_pkg;

    localparam int unsigned BIF_DATA_W = 8;
    localparam int unsigned BIF_ADDR_W = 13;
    localparam int unsigned BIF_SYNC_N = 2;

    // Control strobes as seen by the block, active-low where the bus is.
    typedef struct packed {
        logic ale;
        logic ce_n;
        logic psen_n;
        logic rd_n;
        logic wr_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ale: 1'b0, ce_n: 1'b1, psen_n: 1'b1,
                                        rd_n: 1'b1, wr_n: 1'b1};

    // A read is selected when the chip is enabled, the address phase is over
    // and either read strobe is active.
    function automatic logic read_sel(input strobe_t s);
        return !s.ce_n && !s.ale && (!s.psen_n || !s.rd_n);
    endfunction

    function automatic logic write_sel(input strobe_t s);
        return !s.ce_n && !s.wr_n;
    endfunction

endpackage

// File: rtl/bif_sync.sv
module bif_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= RST_VAL;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/bif_addr_latch.sv
module bif_addr_latch #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned HI_W   = 5,
    localparam int unsigned AW    = DATA_W + HI_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale_s,
    input  logic [DATA_W-1:0] lo_s,
    input  logic [HI_W-1:0]   hi_s,
    output logic [AW-1:0]     addr
);

    // Transparent while the synchronized strobe is high, holds once it drops.
    always_ff @(posedge clk) begin
        if (rst)        addr <= '0;
        else if (ale_s) addr <= {hi_s, lo_s};
    end

endmodule

// File: rtl/bif_read_path.sv
module bif_read_path #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] mem_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] dout,
    output logic              oe
);

    logic sel_q;
    logic pend;
    logic valid;
    logic start;

    assign start = sel && !sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= 1'b0;
            rd_en   <= 1'b0;
            rd_addr <= '0;
            pend    <= 1'b0;
            valid   <= 1'b0;
            dout    <= '0;
        end else begin
            sel_q <= sel;
            rd_en <= start;
            if (start) rd_addr <= addr;
            pend  <= rd_en;
            if (pend && sel) dout <= mem_data;
            valid <= sel && (valid || pend);
        end
    end

    assign oe = sel && valid;

endmodule

// File: rtl/bif_write_path.sv
module bif_write_path #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n_s,
    input  logic              wr_n_s,
    input  logic              active,
    input  logic [DATA_W-1:0] data_s,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic wr_q;
    logic armed;
    logic rise;

    assign rise = armed && wr_n_s && !wr_q && !ce_n_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b1;
            armed   <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_q  <= wr_n_s;
            armed <= active || (armed && !rise && !ce_n_s);
            wr_en <= rise;
            if (rise) begin
                wr_addr <= addr;
                wr_data <= data_s;
            end
        end
    end

endmodule

// File: rtl/mux_bus_mem_if.sv
module mux_bus_mem_if
    import bus_if_pkg::*;
#(
    parameter int unsigned DATA_W      = BIF_DATA_W,
    parameter int unsigned ADDR_W      = BIF_ADDR_W,
    parameter int unsigned SYNC_STAGES = BIF_SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale_i,
    input  logic              ce_n_i,
    input  logic              psen_n_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [ADDR_W-DATA_W-1:0] addr_hi_i,
    inout  wire  [DATA_W-1:0] ad_io,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_rd_addr_o,
    input  logic [DATA_W-1:0] mem_rd_data_i,
    output logic              mem_wr_en_o,
    output logic [ADDR_W-1:0] mem_wr_addr_o,
    output logic [DATA_W-1:0] mem_wr_data_o
);

    localparam int unsigned HI_W  = ADDR_W - DATA_W;
    localparam int unsigned BUS_W = ADDR_W;

    strobe_t           strb_raw;
    strobe_t           strb_s;
    logic [BUS_W-1:0]  bus_s;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] dout;
    logic              ad_oe;
    logic              sync_ce_n;
    logic              sync_ale;

    assign strb_raw = '{ale: ale_i, ce_n: ce_n_i, psen_n: psen_n_i,
                        rd_n: rd_n_i, wr_n: wr_n_i};

    bif_sync #(
        .W       ($bits(strobe_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (STROBE_IDLE)
    ) u_strb_sync (
        .clk (clk),
        .rst (rst),
        .d   (strb_raw),
        .q   (strb_s)
    );

    // Bus lines go through the same depth so they stay aligned with the strobes.
    bif_sync #(
        .W       (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_bus_sync (
        .clk (clk),
        .rst (rst),
        .d   ({addr_hi_i, ad_io}),
        .q   (bus_s)
    );

    assign sync_ce_n = strb_s.ce_n;
    assign sync_ale  = strb_s.ale;

    bif_addr_latch #(
        .DATA_W (DATA_W),
        .HI_W   (HI_W)
    ) u_addr (
        .clk   (clk),
        .rst   (rst),
        .ale_s (strb_s.ale),
        .lo_s  (bus_s[DATA_W-1:0]),
        .hi_s  (bus_s[BUS_W-1:DATA_W]),
        .addr  (addr_q)
    );

    bif_read_path #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .sel      (read_sel(strb_s)),
        .addr     (addr_q),
        .mem_data (mem_rd_data_i),
        .rd_en    (mem_rd_en_o),
        .rd_addr  (mem_rd_addr_o),
        .dout     (dout),
        .oe       (ad_oe)
    );

    bif_write_path #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_wr (
        .clk     (clk),
        .rst     (rst),
        .ce_n_s  (strb_s.ce_n),
        .wr_n_s  (strb_s.wr_n),
        .active  (write_sel(strb_s)),
        .data_s  (bus_s[DATA_W-1:0]),
        .addr    (addr_q),
        .wr_en   (mem_wr_en_o),
        .wr_addr (mem_wr_addr_o),
        .wr_data (mem_wr_data_o)
    );

    assign ad_io = ad_oe ? dout : 'z;

endmodule

// File: rtl/bif_checker.sv
module bif_checker (
    input logic clk,
    input logic rst,
    input logic rd_en,
    input logic wr_en,
    input logic oe,
    input logic ce_s_n,
    input logic ale_s
);

    // R9: a read request lasts a single cycle
    a_r9_rd_single: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en);

    // R8: a write request lasts a single cycle
    a_r8_wr_single: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R7: read request only after chip enable was seen low
    a_r7_rd_needs_ce: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> $past(!ce_s_n));

    // R7: write request only after chip enable was seen low
    a_r7_wr_needs_ce: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(!ce_s_n));

    // R6: lines never driven during the address phase
    a_r6_no_drive_in_addr_phase: assert property (@(posedge clk) disable iff (rst)
        oe |-> !ale_s);

    // R3: driving begins two cycles after the read request
    a_r3_drive_follows_request: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> $past(rd_en, 2));

endmodule

bind mux_bus_mem_if bif_checker u_bif_chk (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (mem_rd_en_o),
    .wr_en  (mem_wr_en_o),
    .oe     (ad_oe),
    .ce_s_n (sync_ce_n),
    .ale_s  (sync_ale)
);

// File: tb/tb_mux_bus_mem_if.sv
`timescale 1ns/1ps
module tb_mux_bus_mem_if;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ale = 1'b0;
    logic        ce_n = 1'b1;
    logic        psen_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [4:0]  hi = '0;
    wire  [7:0]  ad;
    logic        drv_en = 1'b0;
    logic [7:0]  drv_val = '0;
    logic        rd_en, wr_en;
    logic [12:0] rd_addr, wr_addr;
    logic [7:0]  rd_data, wr_data;

    int errors = 0;
    int checks = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;

    logic [7:0] ram     [64];
    logic [7:0] exp_ram [64];

    always #2 clk = ~clk;

    assign ad = drv_en ? drv_val : 'z;
    for (genvar i = 0; i < 8; i++) begin : g_pu
        pullup (ad[i]);
    end

    mux_bus_mem_if dut (
        .clk (clk), .rst (rst), .ale_i (ale), .ce_n_i (ce_n),
        .psen_n_i (psen_n), .rd_n_i (rd_n), .wr_n_i (wr_n),
        .addr_hi_i (hi), .ad_io (ad),
        .mem_rd_en_o (rd_en), .mem_rd_addr_o (rd_addr), .mem_rd_data_i (rd_data),
        .mem_wr_en_o (wr_en), .mem_wr_addr_o (wr_addr), .mem_wr_data_o (wr_data)
    );

    function automatic int idx(input logic [12:0] a);
        return int'({a[12:10], a[2:0]});
    endfunction

    always @(posedge clk) begin
        if (wr_en) begin
            ram[idx(wr_addr)] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (rd_en) begin
            rd_data <= ram[idx(rd_addr)];
            rd_cnt  <= rd_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_addr(input logic [12:0] a);
        @(negedge clk);
        ale = 1'b1; drv_en = 1'b1; drv_val = a[7:0]; hi = a[12:8];
        repeat (3) @(negedge clk);
        ale = 1'b0;
        repeat (2) @(negedge clk);
        drv_val = ~a[7:0]; hi = ~a[12:8];   // must not disturb the held address
        repeat (2) @(negedge clk);
        drv_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read(input bit use_rd, input logic [12:0] a, input string req);
        int c0 = rd_cnt;
        logic [7:0] e = exp_ram[idx(a)];
        set_addr(a);
        @(negedge clk);
        if (use_rd) rd_n = 1'b0; else psen_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(ad == 8'hFF, {req, " released through 4th edge"}, ad, 8'hFF);
        @(posedge clk); @(negedge clk);
        chk(ad == e, {req, "/R2 data at 5th edge"}, ad, e);
        repeat (3) @(negedge clk);
        psen_n = 1'b1; rd_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(ad == 8'hFF, "R5 release after strobe", ad, 8'hFF);
        repeat (3) @(negedge clk);
        chk(rd_cnt == c0 + 1, "R9 one request per read", rd_cnt - c0, 1);
    endtask

    task automatic test_reset;
        repeat (3) @(negedge clk);
        chk(ad == 8'hFF && !rd_en && !wr_en, "R1 in reset", ad, 8'hFF);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk(ad == 8'hFF, "R1 after reset", ad, 8'hFF);
        chk(rd_cnt == 0 && wr_cnt == 0, "R1 no requests", rd_cnt + wr_cnt, 0);
    endtask

    task automatic test_ale_high;
        int c0 = rd_cnt;
        @(negedge clk);
        ale = 1'b1; psen_n = 1'b0;
        repeat (10) @(negedge clk);
        chk(ad == 8'hFF, "R6 no drive while latch strobe high", ad, 8'hFF);
        chk(rd_cnt == c0, "R6 no request while latch strobe high", rd_cnt - c0, 0);
        psen_n = 1'b1; ale = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic test_ce_high;
        int r0 = rd_cnt;
        int w0 = wr_cnt;
        ce_n = 1'b1;
        set_addr(13'h0810);
        rd_n = 1'b0;
        repeat (10) @(negedge clk);
        chk(ad == 8'hFF, "R7 no drive while disabled", ad, 8'hFF);
        chk(rd_cnt == r0, "R7 no read request while disabled", rd_cnt - r0, 0);
        rd_n = 1'b1;
        repeat (3) @(negedge clk);
        drv_en = 1'b1; drv_val = 8'h11; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (8) @(negedge clk);
        drv_en = 1'b0;
        chk(wr_cnt == w0, "R7 no write request while disabled", wr_cnt - w0, 0);
        ce_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_write(input logic [12:0] a, input logic [7:0] d);
        int w0;
        set_addr(a);
        w0 = wr_cnt;
        @(negedge clk);
        drv_en = 1'b1; drv_val = d; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!wr_en, "R8 no request before 3rd edge", wr_en, 0);
        @(posedge clk); @(negedge clk);
        chk(wr_en, "R8 request at 3rd edge", wr_en, 1);
        chk(wr_addr == a, "R8 write address", wr_addr, a);
        chk(wr_data == d, "R8 write data", wr_data, d);
        @(posedge clk); @(negedge clk);
        chk(!wr_en, "R8 single cycle", wr_en, 0);
        drv_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(wr_cnt == w0 + 1, "R8 one request", wr_cnt - w0, 1);
        exp_ram[idx(a)] = d;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            ram[i]     = 8'(8'h40 + i * 3);
            exp_ram[i] = 8'(8'h40 + i * 3);
        end
        rd_data = '0;
        test_reset();
        ce_n = 1'b0;
        do_read(1'b0, 13'h1C05, "R3");
        do_read(1'b0, 13'h0403, "R3");
        do_read(1'b1, 13'h1A06, "R4");
        do_read(1'b1, 13'h0001, "R4");
        chk(wr_cnt == 0, "R10 reads give no write request", wr_cnt, 0);
        test_ale_high();
        test_ce_high();
        do_write(13'h1407, 8'h5A);
        do_read(1'b1, 13'h1407, "R8 readback R4");
        do_write(13'h0C02, 8'hC3);
        do_read(1'b0, 13'h0C02, "R8 readback R3");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule